// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer

This block is an up-counting timer attached to a simple single-cycle register bus. A 16-bit divider sets how many input clock cycles make up one count step. The counter climbs from zero to a programmable limit and then returns to zero. Each return to zero is an update event. If the run bit and the update interrupt enable are both set, the event raises a sticky flag and a one-cycle interrupt pulse.

Software can set the count directly, or clear it with an event-register strike that also restarts the divider phase. Changing the divider never disturbs the visible count. A second group of registers only holds values for software to read back: channel modes, channel enables, four compare values, trigger and burst settings, and an option word. These registers drive nothing. A limit of zero turns update events off.

The bus is combinational on reads. When `bus_req` is high and `bus_we` is low, `bus_rdata` shows the addressed register in the same cycle. A write takes effect at the clock edge on which `bus_req` and `bus_we` are both high. The asynchronous active-low reset is released through a synchroniser inside the block.

Top module: `arl_timer`

## Requirements
- R1: While the run bit (bit 0 at offset 0x00) is set, the count rises by one on every (div+1)-th enabled clock edge. The divider phase starts from 0 after any divider restart.
- R2: A count step taken while the count equals a nonzero limit (offset 0x2C) sets the count to 0 and is an update event. If the update interrupt enable (bit 0 at offset 0x0C) is also set, status bit 0 (offset 0x10) is set and `irq_pulse` is high for exactly the one cycle after that edge.
- R3: With a limit of 0 no update event happens, and the count keeps rising by one per step.
- R4: A status write stores old AND written data. Writing 1 to status bit 0 keeps it, writing 0 clears it, and no write can set it.
- R5: Writing the event register (offset 0x14) with bit 0 set clears the count and restarts the divider phase. The event register always reads 0.
- R6: A divider write (offset 0x28) keeps only bits 15:0, leaves the count unchanged and restarts the divider phase.
- R7: A count write (offset 0x24) loads the written value into the count at that edge.
- R8: While the run bit is clear, the count and the divider phase hold and no interrupt pulse occurs. Register writes still take effect.
- R9: After reset every mapped register reads 0 and `irq_pulse` is low.
- R10: Offsets 0x04, 0x08, 0x18, 0x1C, 0x20, 0x34, 0x38, 0x3C, 0x40, 0x48, 0x4C and 0x50 are 32-bit storage that reads back what was written. Any other offset reads 0, and reading it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, zero when no read is in progress |
| irq_pulse | output | 1 | One-cycle update interrupt |

## Verification
The main counting function is run with several pairs of divider and limit. Divide-by-one with a short limit checks the plain wrap period. Larger dividers separate the step rate from the clock rate, and a run that ends exactly on a wrap tells an off-by-one in either counter apart. A zero limit shows that counting continues with no events. A run with the interrupt disabled shows that wraps still happen while the flag and the pulse stay quiet. Directed cases show that an event strike restarts the divider phase (a stale phase would add one step), that the status register behaves as AND-on-write, and that unmapped reads are inert.

// File: rtl/arl_timer_pkg.sv
package arl_timer_pkg;

  // register slots known to the decoder
  typedef enum logic [4:0] {
    RI_CTRL, RI_AUX, RI_TRIG, RI_IEN, RI_STAT, RI_EVT, RI_MODE_A, RI_MODE_B,
    RI_CHEN, RI_CNT, RI_DIV, RI_LIM, RI_CMP0, RI_CMP1, RI_CMP2, RI_CMP3,
    RI_BCFG, RI_BDAT, RI_OPT, RI_NONE
  } reg_idx_e;

  localparam int MAP_ADDR_W = 8;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_AUX    = 8'h04;
  localparam logic [7:0] OFS_TRIG   = 8'h08;
  localparam logic [7:0] OFS_IEN    = 8'h0C;
  localparam logic [7:0] OFS_STAT   = 8'h10;
  localparam logic [7:0] OFS_EVT    = 8'h14;
  localparam logic [7:0] OFS_MODE_A = 8'h18;
  localparam logic [7:0] OFS_MODE_B = 8'h1C;
  localparam logic [7:0] OFS_CHEN   = 8'h20;
  localparam logic [7:0] OFS_CNT    = 8'h24;
  localparam logic [7:0] OFS_DIV    = 8'h28;
  localparam logic [7:0] OFS_LIM    = 8'h2C;
  localparam logic [7:0] OFS_CMP0   = 8'h34;
  localparam logic [7:0] OFS_CMP1   = 8'h38;
  localparam logic [7:0] OFS_CMP2   = 8'h3C;
  localparam logic [7:0] OFS_CMP3   = 8'h40;
  localparam logic [7:0] OFS_BCFG   = 8'h48;
  localparam logic [7:0] OFS_BDAT   = 8'h4C;
  localparam logic [7:0] OFS_OPT    = 8'h50;

  // bit positions of the single-bit controls
  localparam int BIT_RUN   = 0;
  localparam int BIT_UIE   = 0;
  localparam int BIT_UGEN  = 0;

  // plain 32-bit words held in one array; slot order below
  localparam int NPLAIN    = 14;
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_IEN  = 3;
  localparam reg_idx_e PLAIN_MAP [NPLAIN] = '{
    RI_CTRL, RI_AUX, RI_TRIG, RI_IEN, RI_MODE_A, RI_MODE_B, RI_CHEN,
    RI_CMP0, RI_CMP1, RI_CMP2, RI_CMP3, RI_BCFG, RI_BDAT, RI_OPT
  };

  function automatic reg_idx_e decode_ofs(input logic [7:0] ofs);
    reg_idx_e r;
    case (ofs)
      OFS_CTRL:   r = RI_CTRL;
      OFS_AUX:    r = RI_AUX;
      OFS_TRIG:   r = RI_TRIG;
      OFS_IEN:    r = RI_IEN;
      OFS_STAT:   r = RI_STAT;
      OFS_EVT:    r = RI_EVT;
      OFS_MODE_A: r = RI_MODE_A;
      OFS_MODE_B: r = RI_MODE_B;
      OFS_CHEN:   r = RI_CHEN;
      OFS_CNT:    r = RI_CNT;
      OFS_DIV:    r = RI_DIV;
      OFS_LIM:    r = RI_LIM;
      OFS_CMP0:   r = RI_CMP0;
      OFS_CMP1:   r = RI_CMP1;
      OFS_CMP2:   r = RI_CMP2;
      OFS_CMP3:   r = RI_CMP3;
      OFS_BCFG:   r = RI_BCFG;
      OFS_BDAT:   r = RI_BDAT;
      OFS_OPT:    r = RI_OPT;
      default:    r = RI_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/arl_timer_regfile.sv
module arl_timer_regfile
  import arl_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              stat_set,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              run_en,
  output logic              uie,
  output logic [DIV_W-1:0]  div_q,
  output logic [CNT_W-1:0]  limit_q,
  output logic              cnt_ld,
  output logic              evt_ug,
  output logic              div_wr,
  output logic              stat_q
);

  reg_idx_e idx;
  logic     wr;

  logic [DATA_W-1:0] plain_q [NPLAIN];
  logic [DATA_W-1:0] plain_d [NPLAIN];
  logic [DIV_W-1:0]  div_d;
  logic [CNT_W-1:0]  limit_d;
  logic              stat_d;

  // address decode; anything above the map window is unmapped
  always_comb begin
    if ((bus_addr >> MAP_ADDR_W) == '0) idx = decode_ofs(bus_addr[MAP_ADDR_W-1:0]);
    else                                idx = RI_NONE;
  end

  assign wr     = bus_req & bus_we;
  assign cnt_ld = wr & (idx == RI_CNT);
  assign evt_ug = wr & (idx == RI_EVT) & bus_wdata[BIT_UGEN];
  assign div_wr = wr & (idx == RI_DIV);

  // next state
  always_comb begin
    for (int p = 0; p < NPLAIN; p++) begin
      plain_d[p] = (wr && (idx == PLAIN_MAP[p])) ? bus_wdata : plain_q[p];
    end
    div_d   = div_wr ? bus_wdata[DIV_W-1:0] : div_q;
    limit_d = (wr && (idx == RI_LIM)) ? bus_wdata[CNT_W-1:0] : limit_q;
    stat_d  = (wr && (idx == RI_STAT)) ? (stat_q & bus_wdata[0]) : stat_q;
    stat_d  = stat_d | stat_set;  // hardware set wins over a clearing write
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPLAIN; p++) plain_q[p] <= '0;
      div_q   <= '0;
      limit_q <= '0;
      stat_q  <= 1'b0;
    end else begin
      for (int p = 0; p < NPLAIN; p++) plain_q[p] <= plain_d[p];
      div_q   <= div_d;
      limit_q <= limit_d;
      stat_q  <= stat_d;
    end
  end

  assign run_en = plain_q[SLOT_CTRL][BIT_RUN];
  assign uie    = plain_q[SLOT_IEN][BIT_UIE];

  // combinational read port; event register and unmapped offsets give zero
  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_we) begin
      for (int p = 0; p < NPLAIN; p++) begin
        if (idx == PLAIN_MAP[p]) bus_rdata = plain_q[p];
      end
      case (idx)
        RI_STAT: bus_rdata[0] = stat_q;
        RI_CNT:  bus_rdata    = DATA_W'(cnt_q);
        RI_DIV:  bus_rdata    = DATA_W'(div_q);
        RI_LIM:  bus_rdata    = DATA_W'(limit_q);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/arl_timer_prescaler.sv
module arl_timer_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick,
  output logic [DIV_W-1:0] pre_q
);

  logic [DIV_W-1:0] pre_d;
  logic             at_end;

  assign at_end = (pre_q == div);
  // a restart swallows the step so the visible count is untouched
  assign tick   = en & ~restart & at_end;

  always_comb begin
    pre_d = pre_q;
    if (restart)  pre_d = '0;
    else if (en)  pre_d = at_end ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/arl_timer_counter.sv
module arl_timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             upd
);

  logic [CNT_W-1:0] cnt_d;
  logic             hit;

  assign hit = (limit != '0) & (cnt_q == limit);
  assign upd = tick & ~ld & ~clr & hit;

  // priority: software load, then update-generate clear, then step
  always_comb begin
    cnt_d = cnt_q;
    if (ld)        cnt_d = ld_val;
    else if (clr)  cnt_d = '0;
    else if (tick) cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/arl_timer.sv
module arl_timer
  import arl_timer_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 32,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse
);

  logic             rst_n_s;
  logic             run_en, uie, cnt_ld, evt_ug, div_wr, stat_q;
  logic [DIV_W-1:0] div_q, pre_q;
  logic [CNT_W-1:0] limit_q, cnt_q;
  logic             tick, upd, fire;
  logic             irq_d, irq_q;

  // reset: asserted asynchronously, released on a clock edge
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= 1'b0;
        else        rs_q <= 1'b1;
      end
      assign rst_n_s = rs_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_n_s = rs_q[SYNC_STAGES-1];
    end
  endgenerate

  arl_timer_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n_s),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cnt_q(cnt_q), .stat_set(fire),
    .bus_rdata(bus_rdata), .run_en(run_en), .uie(uie), .div_q(div_q),
    .limit_q(limit_q), .cnt_ld(cnt_ld), .evt_ug(evt_ug), .div_wr(div_wr),
    .stat_q(stat_q)
  );

  arl_timer_prescaler #(.DIV_W(DIV_W)) pre_i (
    .clk(clk), .rst_n(rst_n_s), .en(run_en), .restart(evt_ug | div_wr),
    .div(div_q), .tick(tick), .pre_q(pre_q)
  );

  arl_timer_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .ld(cnt_ld),
    .ld_val(bus_wdata[CNT_W-1:0]), .clr(evt_ug), .limit(limit_q),
    .cnt_q(cnt_q), .upd(upd)
  );

  assign fire  = upd & uie & run_en;
  assign irq_d = fire;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign irq_pulse = irq_q;

endmodule

// File: rtl/arl_timer_chk.sv
module arl_timer_chk
  import arl_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_pulse,
  input logic              run_en,
  input logic              stat_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  limit_q,
  input logic [DIV_W-1:0]  pre_q
);

  logic any_wr, wr_evt, wr_div, wr_cnt;
  assign any_wr = bus_req && bus_we;
  assign wr_evt = any_wr && (bus_addr == ADDR_W'(OFS_EVT)) && bus_wdata[BIT_UGEN];
  assign wr_div = any_wr && (bus_addr == ADDR_W'(OFS_DIV));
  assign wr_cnt = any_wr && (bus_addr == ADDR_W'(OFS_CNT));

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |=> !irq_pulse); // R2
  AST_IRQ_FLAGS_STATUS: assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |-> stat_q); // R2
  AST_IRQ_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n) irq_pulse |-> (cnt_q == '0)); // R2
  AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (limit_q == '0) |=> !irq_pulse); // R3
  AST_STATUS_HW_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat_q) |-> irq_pulse); // R4
  AST_UGEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) wr_evt |=> (cnt_q == '0 && pre_q == '0)); // R5
  AST_DIV_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) wr_div |=> ($stable(cnt_q) && pre_q == '0)); // R6
  AST_COUNT_LOADS: assert property (@(posedge clk) disable iff (!rst_n) wr_cnt |=> (cnt_q == $past(bus_wdata[CNT_W-1:0]))); // R7
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!run_en && !any_wr) |=> ($stable(cnt_q) && $stable(pre_q))); // R8
  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !run_en |=> !irq_pulse); // R8

endmodule

bind arl_timer arl_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)
) chk_i (
  .clk(clk), .rst_n(rst_n_s), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_pulse(irq_pulse),
  .run_en(run_en), .stat_q(stat_q), .cnt_q(cnt_q), .limit_q(limit_q),
  .pre_q(pre_q)
);

// File: tb/arl_timer_tb_top.sv
module arl_timer_tb_top;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk;
  logic              rst_n;
  logic              bus_req;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq_pulse;

  int n_cmp;
  int n_bad;
  int irq_seen;
  bit done;

  arl_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) if (irq_pulse === 1'b1) irq_seen++;

  // vector table: divider, limit, enabled cycles, interrupt enable
  localparam int NVEC = 6;
  localparam int unsigned V_DIV [NVEC] = '{0, 2, 1, 4, 3, 0};
  localparam int unsigned V_LIM [NVEC] = '{4, 3, 0, 1, 7, 2};
  localparam int unsigned V_RUN [NVEC] = '{20, 30, 15, 49, 7, 8};
  localparam int unsigned V_IEN [NVEC] = '{1, 1, 1, 1, 1, 0};

  localparam int NMAP = 19;
  localparam logic [7:0] MAPPED [NMAP] = '{
    8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24,
    8'h28, 8'h2C, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h48, 8'h4C, 8'h50
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // tasks are entered on a falling edge and leave on the next one
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    int unsigned steps, upd_n, exp_cnt;
    n_cmp = 0; n_bad = 0; irq_seen = 0; done = 0;
    bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    chk("R9 irq_pulse", {31'b0, irq_pulse}, 32'h0);
    for (int i = 0; i < NMAP; i++) begin
      bus_read(MAPPED[i], rd);
      chk("R9 reg", rd, 32'h0);
    end

    // table walk: R1, R2, R3
    for (int v = 0; v < NVEC; v++) begin
      bus_write(8'h10, 32'h0);
      bus_write(8'h28, V_DIV[v]);
      bus_write(8'h2C, V_LIM[v]);
      bus_write(8'h24, 32'h0);
      bus_write(8'h0C, V_IEN[v]);
      irq_seen = 0;
      bus_write(8'h00, 32'h1);
      repeat (V_RUN[v]) @(negedge clk);
      bus_write(8'h00, 32'h0);
      repeat (3) @(negedge clk);
      steps = (V_RUN[v] + 1) / (V_DIV[v] + 1);
      if (V_LIM[v] == 0) begin
        exp_cnt = steps; upd_n = 0;
      end else begin
        exp_cnt = steps % (V_LIM[v] + 1); upd_n = steps / (V_LIM[v] + 1);
      end
      bus_read(8'h24, rd);
      chk((V_LIM[v] == 0) ? "R3 count" : "R1 count", rd, exp_cnt);
      chk("R2 pulses", irq_seen, (V_IEN[v] != 0) ? upd_n : 0);
      bus_read(8'h10, rd);
      chk("R2 status", rd, ((V_IEN[v] != 0) && (upd_n > 0)) ? 32'h1 : 32'h0);
    end

    // R7 load, R5 clear with phase restart, R8 hold
    bus_write(8'h2C, 32'h0);
    bus_write(8'h28, 32'h3);
    bus_write(8'h24, 32'd37);
    bus_read(8'h24, rd);
    chk("R7 count load", rd, 32'd37);
    bus_write(8'h00, 32'h1);
    @(negedge clk);
    bus_write(8'h14, 32'h1);
    repeat (2) @(negedge clk);
    bus_write(8'h00, 32'h0);
    bus_read(8'h24, rd);
    chk("R5 cleared, phase restarted", rd, 32'h0);
    bus_read(8'h14, rd);
    chk("R5 event reads zero", rd, 32'h0);
    repeat (10) @(negedge clk);
    bus_read(8'h24, rd);
    chk("R8 hold while off", rd, 32'h0);
    bus_write(8'h00, 32'h1);
    bus_write(8'h00, 32'h0);
    bus_read(8'h24, rd);
    chk("R8 phase kept across stop", rd, 32'h1);

    // R6 divider write
    bus_write(8'h24, 32'd100);
    bus_write(8'h28, 32'h1234ABCD);
    bus_read(8'h24, rd);
    chk("R6 count kept", rd, 32'd100);
    bus_read(8'h28, rd);
    chk("R6 low half kept", rd, 32'h0000ABCD);

    // R4 status write semantics
    bus_write(8'h28, 32'h0);
    bus_write(8'h2C, 32'h1);
    bus_write(8'h24, 32'h1);
    bus_write(8'h0C, 32'h1);
    bus_write(8'h10, 32'h0);
    bus_write(8'h00, 32'h1);
    bus_write(8'h00, 32'h0);
    bus_read(8'h10, rd);
    chk("R4 flag set by wrap", rd, 32'h1);
    bus_write(8'h10, 32'hFFFFFFFF);
    bus_read(8'h10, rd);
    chk("R4 ones keep flag", rd, 32'h1);
    bus_write(8'h10, 32'h0);
    bus_read(8'h10, rd);
    chk("R4 zero clears", rd, 32'h0);
    bus_write(8'h10, 32'hFFFFFFFF);
    bus_read(8'h10, rd);
    chk("R4 no software set", rd, 32'h0);

    // R10 storage and unmapped offsets
    bus_write(8'h3C, 32'hDEADBEEF);
    bus_read(8'h3C, rd);
    chk("R10 compare storage", rd, 32'hDEADBEEF);
    bus_write(8'h50, 32'h12345678);
    bus_read(8'h50, rd);
    chk("R10 option storage", rd, 32'h12345678);
    bus_write(8'h08, 32'h0000F00D);
    bus_read(8'h08, rd);
    chk("R10 trigger storage", rd, 32'h0000F00D);
    bus_read(8'h24, rd2);
    bus_read(8'h30, rd);
    chk("R10 unmapped 0x30", rd, 32'h0);
    bus_read(8'h44, rd);
    chk("R10 unmapped 0x44", rd, 32'h0);
    bus_read(8'h54, rd);
    chk("R10 unmapped 0x54", rd, 32'h0);
    bus_read(8'h02, rd);
    chk("R10 misaligned", rd, 32'h0);
    bus_read(8'h24, rd);
    chk("R10 no side effect", rd, rd2);

    done = 1;
    summary();
    $finish;
  end

endmodule